// File: doc/BRIEF.md
# SPI Flash User-Command Sequencer

The sequencer is an SPI master that runs one flash transaction built from latched settings: an 8-bit opcode, an optional outgoing data phase and an optional incoming data phase, all in a single chip-select frame. An optional prefix opcode can come first. It is sent as a separate 8-bit frame with no data, and the main frame follows it directly, with no other transfer between the two. This suits flash commands that must immediately follow an enable command.

The host loads a 16-word (64-byte) buffer through a word write port and pulses `start`. Outgoing data comes from the buffer and incoming data goes back into it, using the same bit mapping. While `busy` is high, buffer writes and further start pulses are ignored. When `busy` falls, `status` gives the result. The bus runs in SPI mode 0 with single-bit data.

The controller has five states:
- ST_IDLE: waiting for a start pulse.
- ST_SETUP: chip select is low and SCLK is held low for the setup time.
- ST_SHIFT: bits are clocked out and in.
- ST_GAP: chip select is high between frames or after the last frame.
- ST_TRIM: unreceived bits of the last buffer word are cleared.

The transitions are:
- IDLE→SETUP on a valid start.
- SETUP→SHIFT when the setup count expires.
- SHIFT→GAP after the last bit of a frame.
- GAP→SETUP if the frame just finished was the prefix; otherwise GAP→TRIM.
- TRIM→IDLE.
- Any busy state→IDLE on timeout.

Top module: `spi_user_seq`

## Requirements
- R1: A frame shifts the 8-bit opcode MSB first, then `wr_bits` outgoing bits, then `rd_bits` incoming bits, all with `cs_n` held low, so the frame has 8+`wr_bits`+`rd_bits` SCLK rising edges.
- R2: Outgoing stream bit k (k counted from 0) is taken from buffer bit position k XOR 7, where position = 32·word + bit. This sends buffer byte 0 first, the low byte of each word first, and each byte MSB first. A partial final byte therefore uses that byte's high bits.
- R3: Incoming stream bit k is stored at buffer position k XOR 7. When the transfer ends and `rd_bits` is not a multiple of 32, every bit of word `rd_bits`/32 that was not received is cleared. Positions outside that word that were not received keep their contents.
- R4: A start with `wr_bits` or `rd_bits` above 512 produces no `cs_n` activity, leaves `busy` low and sets `status` to 1 (error) on the next cycle.
- R5: With a nonzero `pre_op`, exactly two frames occur: an 8-bit frame carrying `pre_op`, then the main frame. With `pre_op` = 0, exactly one frame occurs.
- R6: `cs_n` falls at least `cs_setup` SCLK periods before the first SCLK rising edge of each frame, and stays high at least one SCLK period between frames.
- R7: SCLK idles low and toggles only while `cs_n` is low. Its period is 2·(`clk_div`+1) clock cycles. MOSI changes only while SCLK is low, and MISO is sampled on the rising edge.
- R8: `busy` rises on the cycle after an accepted start and stays high until after `cs_n` rises at the end of the last frame. The operation then ends with `status` 0 (ok).
- R9: If a transaction is still busy after TIMEOUT_CYC clock cycles, it is aborted: `cs_n` goes high, SCLK goes low, `busy` falls and `status` becomes 2 (timeout).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to run a transaction |
| opcode | input | 8 | Main command opcode |
| pre_op | input | 8 | Prefix opcode; 0 means no prefix frame |
| wr_bits | input | 10 | Outgoing data length in bits (0..512) |
| rd_bits | input | 10 | Incoming data length in bits (0..512) |
| clk_div | input | 8 | SCLK half period is clk_div+1 clock cycles |
| cs_setup | input | 4 | SCLK periods from cs_n low to the first SCLK edge |
| buf_we | input | 1 | Buffer word write enable (ignored while busy) |
| buf_waddr | input | 4 | Buffer word write address |
| buf_wdata | input | 32 | Buffer word write data |
| buf_raddr | input | 4 | Buffer word read address |
| buf_rdata | output | 32 | Buffer word read data (combinational) |
| busy | output | 1 | Transaction in progress |
| status | output | 2 | 0 ok, 1 length error, 2 timeout |
| sclk | output | 1 | SPI clock |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench targets the XOR-7 bit mapping with lengths that end inside a byte. A design that shifted LSB first, or put a partial byte in the low bits, would show mismatched stream bits and wrong read-back words. It also targets the trim of the last read word alongside untouched neighbouring words, because an off-by-one mask would either leave stale bits or wipe bits that were received. Prefix chaining is checked by counting frames and measuring the chip-select gap and setup time: a merged or missing prefix frame, or SCLK starting too early, shows up directly. The 512-bit limit, an over-long request that must leave the bus silent, and a slow clock that must time out are the remaining edges.

// File: rtl/spiseq_pkg.sv
package spiseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_GAP,
        ST_TRIM
    } seq_state_t;

    typedef enum logic [1:0] {
        RES_OK  = 2'd0,
        RES_ERR = 2'd1,
        RES_TMO = 2'd2
    } seq_res_t;

endpackage

// File: rtl/spiseq_tick.sv
module spiseq_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = en && (cnt_q == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/spi_user_seq.sv
module spi_user_seq
    import spiseq_pkg::*;
#(
    parameter int BUF_WORDS   = 16,
    parameter int DIV_W       = 8,
    parameter int SETUP_W     = 4,
    parameter int TIMEOUT_CYC = 20000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [7:0]                    opcode,
    input  logic [7:0]                    pre_op,
    input  logic [$clog2(BUF_WORDS*32):0] wr_bits,
    input  logic [$clog2(BUF_WORDS*32):0] rd_bits,
    input  logic [DIV_W-1:0]              clk_div,
    input  logic [SETUP_W-1:0]            cs_setup,
    input  logic                          buf_we,
    input  logic [$clog2(BUF_WORDS)-1:0]  buf_waddr,
    input  logic [31:0]                   buf_wdata,
    input  logic [$clog2(BUF_WORDS)-1:0]  buf_raddr,
    output logic [31:0]                   buf_rdata,
    output logic                          busy,
    output logic [1:0]                    status,
    output logic                          sclk,
    output logic                          cs_n,
    output logic                          mosi,
    input  logic                          miso
);
    localparam int BUF_BITS = BUF_WORDS * 32;
    localparam int IDX_W    = $clog2(BUF_BITS);
    localparam int LEN_W    = IDX_W + 1;
    localparam int FRAME_W  = LEN_W + 2;
    localparam int TMO_W    = $clog2(TIMEOUT_CYC + 1);

    seq_state_t state_q, state_d;
    seq_res_t   res_q;

    logic [7:0]          op_q, pre_q;
    logic [LEN_W-1:0]    wr_q, rd_q;
    logic [SETUP_W-1:0]  setup_q;
    logic                in_pre_q, ph_q, sclk_q, cs_q, mosi_q;
    logic [FRAME_W-1:0]  bitn_q;
    logic [SETUP_W:0]    tcnt_q;
    logic [TMO_W-1:0]    tmo_q;
    logic [BUF_BITS-1:0] buf_q;

    logic                tick, req_bad, tmo_hit, last_bit, rd_phase, tx_next;
    logic [FRAME_W-1:0]  nxt_n, frame_last, wr_ext, woff, roff;
    logic [IDX_W-1:0]    widx, ridx, trim_base;
    logic [7:0]          op_cur;
    logic [31:0]         trim_keep;

    spiseq_tick #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (state_q != ST_IDLE),
        .div  (clk_div),
        .tick (tick)
    );

    // Stream bookkeeping and bit-to-buffer mapping (position = index XOR 7)
    always_comb begin
        req_bad    = (wr_bits > LEN_W'(BUF_BITS)) || (rd_bits > LEN_W'(BUF_BITS));
        tmo_hit    = (tmo_q == TMO_W'(TIMEOUT_CYC - 1));
        wr_ext     = FRAME_W'(wr_q);
        frame_last = in_pre_q ? FRAME_W'(7) : FRAME_W'(7) + wr_ext + FRAME_W'(rd_q);
        last_bit   = (bitn_q == frame_last);
        rd_phase   = (bitn_q >= FRAME_W'(8) + wr_ext);
        nxt_n      = bitn_q + 1'b1;
        woff       = nxt_n - FRAME_W'(8);
        roff       = bitn_q - FRAME_W'(8) - wr_ext;
        widx       = woff[IDX_W-1:0] ^ IDX_W'(7);
        ridx       = roff[IDX_W-1:0] ^ IDX_W'(7);
        op_cur     = in_pre_q ? pre_q : op_q;
        if (nxt_n < FRAME_W'(8))
            tx_next = op_cur[3'd7 - nxt_n[2:0]];
        else if (nxt_n < FRAME_W'(8) + wr_ext)
            tx_next = buf_q[widx];
        else
            tx_next = 1'b0;
        trim_base = {rd_q[IDX_W-1:5], 5'd0};
        for (int j = 0; j < 32; j++)
            trim_keep[j] = ((5'(j) ^ 5'd7) < rd_q[4:0]);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start && !req_bad) state_d = ST_SETUP;
            ST_SETUP: if (tick && (tcnt_q + 1'b1 >= {setup_q, 1'b0})) state_d = ST_SHIFT;
            ST_SHIFT: if (tick && ph_q && last_bit) state_d = ST_GAP;
            ST_GAP:   if (tick && tcnt_q == (SETUP_W+1)'(1))
                          state_d = in_pre_q ? ST_SETUP : ST_TRIM;
            ST_TRIM:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
        if (state_q != ST_IDLE && tmo_hit) state_d = ST_IDLE;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= RES_OK;  op_q <= '0;  pre_q <= '0;  wr_q <= '0;  rd_q <= '0;
            setup_q <= '0;  in_pre_q <= 1'b0;  ph_q <= 1'b0;  sclk_q <= 1'b0;
            cs_q <= 1'b1;  mosi_q <= 1'b0;  bitn_q <= '0;  tcnt_q <= '0;
            tmo_q <= '0;  buf_q <= '0;
        end else if (state_q == ST_IDLE) begin
            if (buf_we) buf_q[{buf_waddr, 5'd0} +: 32] <= buf_wdata;
            if (start) begin
                if (req_bad) begin
                    res_q <= RES_ERR;
                end else begin
                    op_q <= opcode;  pre_q <= pre_op;  wr_q <= wr_bits;  rd_q <= rd_bits;
                    setup_q  <= cs_setup;
                    in_pre_q <= (pre_op != 8'd0);
                    mosi_q   <= (pre_op != 8'd0) ? pre_op[7] : opcode[7];
                    cs_q <= 1'b0;  bitn_q <= '0;  tcnt_q <= '0;  ph_q <= 1'b0;  tmo_q <= '0;
                end
            end
        end else if (tmo_hit) begin
            cs_q <= 1'b1;  sclk_q <= 1'b0;  res_q <= RES_TMO;
        end else begin
            tmo_q <= tmo_q + 1'b1;
            unique case (state_q)
                ST_SETUP: if (tick) tcnt_q <= tcnt_q + 1'b1;
                ST_SHIFT: if (tick) begin
                    if (!ph_q) begin
                        sclk_q <= 1'b1;
                        ph_q   <= 1'b1;
                        if (rd_phase) buf_q[ridx] <= miso;
                    end else begin
                        sclk_q <= 1'b0;
                        ph_q   <= 1'b0;
                        if (last_bit) begin
                            cs_q   <= 1'b1;
                            tcnt_q <= '0;
                        end else begin
                            bitn_q <= nxt_n;
                            mosi_q <= tx_next;
                        end
                    end
                end
                ST_GAP: if (tick) begin
                    tcnt_q <= tcnt_q + 1'b1;
                    if (tcnt_q == (SETUP_W+1)'(1) && in_pre_q) begin
                        in_pre_q <= 1'b0;
                        cs_q     <= 1'b0;
                        mosi_q   <= op_q[7];
                        bitn_q   <= '0;
                        tcnt_q   <= '0;
                    end
                end
                ST_TRIM: begin
                    if (rd_q[4:0] != 5'd0)
                        buf_q[trim_base +: 32] <= buf_q[trim_base +: 32] & trim_keep;
                    res_q <= RES_OK;
                end
                default: ;
            endcase
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign status    = res_q;
    assign sclk      = sclk_q;
    assign cs_n      = cs_q;
    assign mosi      = mosi_q;
    assign buf_rdata = buf_q[{buf_raddr, 5'd0} +: 32];

    // Assertions
    p_bad_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && req_bad) |=> (!busy && cs_n && status == 2'd1));

    p_setup_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETUP) |-> (!sclk && !cs_n));

    p_sclk_framed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);

    p_mosi_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    p_idle_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n && !sclk));

    p_end_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> cs_n);

    p_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (tmo_q < TMO_W'(TIMEOUT_CYC)));
endmodule

// File: tb/test_spi_user_seq.sv
module test_spi_user_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0, pre_op = '0;
    logic [9:0]  wr_bits = '0, rd_bits = '0;
    logic [7:0]  clk_div = 8'd1;
    logic [3:0]  cs_setup = 4'd1;
    logic        buf_we = 1'b0;
    logic [3:0]  buf_waddr = '0, buf_raddr = '0;
    logic [31:0] buf_wdata = '0;
    logic [31:0] buf_rdata;
    logic        busy, sclk, cs_n, mosi, miso;
    logic [1:0]  status;

    always #10 clk = ~clk;

    spi_user_seq i_spi_user_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .pre_op(pre_op),
        .wr_bits(wr_bits), .rd_bits(rd_bits), .clk_div(clk_div), .cs_setup(cs_setup),
        .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
        .buf_raddr(buf_raddr), .buf_rdata(buf_rdata), .busy(busy), .status(status),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    int n_chk = 0, n_fail = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Flash-side model
    int          fr, nb, cyc = 0, cur_wr = 0;
    logic [1031:0] cap [4];
    int          flen [4];
    int          t_fall, t_rise, t_last, setup_min, gap_min, per_meas;
    bit          busy_at_end;
    logic [511:0] rpat;
    logic [511:0] shadow;

    always @(posedge clk) cyc++;

    always @(negedge cs_n) begin
        t_fall = cyc;
        if (fr > 0 && (cyc - t_rise) < gap_min) gap_min = cyc - t_rise;
    end

    always @(posedge cs_n) begin
        if (fr < 4) flen[fr] = nb;
        fr++;
        nb = 0;
        t_rise = cyc;
        busy_at_end = busy;
    end

    always @(posedge sclk) begin
        if (nb == 0) begin
            if ((cyc - t_fall) < setup_min) setup_min = cyc - t_fall;
        end else begin
            per_meas = cyc - t_last;
        end
        t_last = cyc;
        if (fr < 4 && nb < 1032) cap[fr][nb] = mosi;
        nb++;
    end

    always_comb begin
        int k;
        k = nb - 8 - cur_wr;
        miso = (!cs_n && k >= 0 && k < 512) ? rpat[k] : 1'b0;
    end

    task automatic model_clear();
        fr = 0; nb = 0; setup_min = 1000000; gap_min = 1000000; per_meas = 0;
        busy_at_end = 1'b0;
        for (int i = 0; i < 4; i++) begin cap[i] = '0; flen[i] = 0; end
    endtask

    task automatic wr_word(input int a, input logic [31:0] d);
        @(negedge clk);
        buf_we = 1'b1; buf_waddr = 4'(a); buf_wdata = d;
        @(negedge clk);
        buf_we = 1'b0;
        shadow[a*32 +: 32] = d;
    endtask

    task automatic preload(input logic [31:0] seed);
        for (int w = 0; w < 16; w++) wr_word(w, seed ^ (32'h01010101 * w) ^ {w[7:0], 24'h5A3C96});
    endtask

    task automatic run_cmd(input logic [7:0] op, input logic [7:0] pre, input int wr, input int rd,
                           input int dv, input int su, output int bcyc);
        model_clear();
        cur_wr = wr; opcode = op; pre_op = pre; wr_bits = 10'(wr); rd_bits = 10'(rd);
        clk_div = 8'(dv); cs_setup = 4'(su);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        bcyc = 1;
        while (busy) begin @(negedge clk); bcyc++; end
    endtask

    // Expected effect of a read on the buffer (R3)
    task automatic apply_read(input int rd);
        for (int p = 0; p < 512; p++) if ((p ^ 7) < rd) shadow[p] = rpat[p ^ 7];
        if (rd % 32 != 0)
            for (int p = 0; p < 32; p++)
                if ((((rd / 32) * 32 + p) ^ 7) >= rd) shadow[(rd / 32) * 32 + p] = 1'b0;
    endtask

    task automatic check_buffer(input string req);
        for (int w = 0; w < 16; w++) begin
            @(negedge clk); buf_raddr = 4'(w); #1;
            check(buf_rdata === shadow[w*32 +: 32], req, $sformatf("buffer word %0d", w),
                  buf_rdata, shadow[w*32 +: 32]);
        end
    endtask

    function automatic logic [7:0] cap_byte(input int f, input int start_bit);
        logic [7:0] b;
        for (int i = 0; i < 8; i++) b[7 - i] = cap[f][start_bit + i];
        return b;
    endfunction

    function automatic int stream_errs(input int f, input int wr);
        int e = 0;
        for (int k = 0; k < wr; k++) if (cap[f][8 + k] !== shadow[k ^ 7]) e++;
        return e;
    endfunction

    task automatic t_reset();
        check(busy === 1'b0, "R8", "busy after reset", busy, 0);
        check(cs_n === 1'b1 && sclk === 1'b0, "R7", "bus idle after reset", {cs_n, sclk}, 2'b10);
        check(status === 2'd0, "R8", "status after reset", status, 0);
    endtask

    task automatic t_plain_read();
        int bc;
        preload(32'h13579BDF);
        rpat = {16{32'hC3A51E97}} ^ {8{64'h0F0F_3C3C_55AA_9966}};
        run_cmd(8'h9F, 8'h00, 0, 24, 1, 1, bc);
        check(fr == 1, "R5", "frame count without prefix", fr, 1);
        check(flen[0] == 32, "R1", "edges in read frame", flen[0], 32);
        check(cap_byte(0, 0) == 8'h9F, "R1", "opcode bits", cap_byte(0, 0), 8'h9F);
        check(status == 2'd0, "R8", "status ok", status, 0);
        check(busy_at_end, "R8", "busy held until cs_n rose", busy_at_end, 1);
        check(per_meas == 4, "R7", "sclk period div=1", per_meas, 4);
        apply_read(24);
        check_buffer("R3");
    endtask

    task automatic t_write();
        int bc;
        preload(32'hA5C30F81);
        run_cmd(8'h02, 8'h00, 40, 0, 1, 1, bc);
        check(flen[0] == 48, "R1", "edges in write frame", flen[0], 48);
        check(stream_errs(0, 40) == 0, "R2", "write stream bit errors", stream_errs(0, 40), 0);
        check(cap_byte(0, 8) == shadow[7:0], "R2", "first data byte is buffer byte 0",
              cap_byte(0, 8), shadow[7:0]);
        check_buffer("R2");
    endtask

    task automatic t_partial();
        int bc;
        preload(32'h6E2D91B4);
        rpat = {32{16'hB2D7}};
        run_cmd(8'h3B, 8'h00, 13, 13, 0, 2, bc);
        check(flen[0] == 34, "R1", "edges in partial frame", flen[0], 34);
        check(stream_errs(0, 13) == 0, "R2", "partial-byte write bits", stream_errs(0, 13), 0);
        check(per_meas == 2, "R7", "sclk period div=0", per_meas, 2);
        check(setup_min >= 4, "R6", "setup time, 2 periods", setup_min, 4);
        apply_read(13);
        check_buffer("R3");
    endtask

    task automatic t_prefix();
        int bc;
        preload(32'h0BADF00D);
        run_cmd(8'h01, 8'h50, 8, 0, 2, 3, bc);
        check(fr == 2, "R5", "frame count with prefix", fr, 2);
        check(flen[0] == 8, "R5", "prefix frame length", flen[0], 8);
        check(cap_byte(0, 0) == 8'h50, "R5", "prefix opcode", cap_byte(0, 0), 8'h50);
        check(flen[1] == 16, "R1", "main frame length", flen[1], 16);
        check(cap_byte(1, 0) == 8'h01, "R5", "main opcode after prefix", cap_byte(1, 0), 8'h01);
        check(cap_byte(1, 8) == shadow[7:0], "R2", "main data byte", cap_byte(1, 8), shadow[7:0]);
        check(setup_min >= 18, "R6", "setup 3 periods div=2", setup_min, 18);
        check(gap_min >= 6, "R6", "cs_n gap between frames", gap_min, 6);
        check(per_meas == 6, "R7", "sclk period div=2", per_meas, 6);
        check(busy_at_end && status == 2'd0, "R8", "busy across both frames", busy_at_end, 1);
    endtask

    task automatic t_max();
        int bc;
        preload(32'h7F00FF81);
        rpat = {8{64'hDEADBEEF_F00DCAFE}} ^ {16{32'h12481248}};
        run_cmd(8'h4B, 8'h00, 512, 512, 0, 0, bc);
        check(flen[0] == 1032, "R1", "edges at maximum length", flen[0], 1032);
        check(stream_errs(0, 512) == 0, "R2", "full-buffer write bits", stream_errs(0, 512), 0);
        apply_read(512);
        check_buffer("R3");
    endtask

    task automatic t_error();
        int bc;
        run_cmd(8'h03, 8'h00, 513, 0, 1, 1, bc);
        check(status == 2'd1, "R4", "status for wr_bits=513", status, 1);
        check(bc == 1 && busy == 1'b0, "R4", "busy stays low", bc, 1);
        run_cmd(8'h03, 8'h50, 0, 600, 1, 1, bc);
        repeat (20) @(negedge clk);
        check(status == 2'd1, "R4", "status for rd_bits=600", status, 1);
        check(fr == 0 && cs_n == 1'b1, "R4", "no bus activity", fr, 0);
    endtask

    task automatic t_timeout();
        int bc;
        run_cmd(8'h02, 8'h00, 512, 0, 255, 1, bc);
        check(status == 2'd2, "R9", "timeout status", status, 2);
        check(bc >= 19990 && bc <= 20010, "R9", "busy cycles before abort", bc, 20000);
        check(cs_n == 1'b1 && sclk == 1'b0, "R9", "bus released on abort", {cs_n, sclk}, 2'b10);
        run_cmd(8'h05, 8'h00, 0, 8, 1, 1, bc);
        check(status == 2'd0 && flen[0] == 16, "R9", "recovery after timeout", status, 0);
    endtask

    initial begin
        shadow = '0;
        rpat = '0;
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        model_clear();
        t_reset();
        t_plain_read();
        t_write();
        t_partial();
        t_prefix();
        t_max();
        t_error();
        t_timeout();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule